// File: doc/BRIEF.md
# Optical Black Clamp Window Generator

This block turns the pixel, line and vertical-transfer counts of a CCD readout sequencer into the per-pixel control strobes of the analog front end that digitises the sensor output. It drives three active-low strobes:

- the optical-black clamp;
- the DC-restore input clamp;
- pixel blanking.

It also drives three active-high qualifiers for a frame grabber: frame, line and pixel.

All outputs are registered. Each one changes on a single pixel-clock edge, one cycle after the counts that select it.

The black clamp has four modes:

- dark pixels at the tail of every line;
- a block of dark rows at the top of the frame;
- both of these windows;
- never, in which case the clamp output is held high.

The mode input is captured only on the frame-start pulse. A mode change therefore always takes effect at a frame boundary and never cuts a window short.

Top module: `obc_strobe_gen`

## Requirements
- R1: With captured mode 0 (the reset value), `obc_n` is low exactly when `pix_cnt` lies in 696..706 inclusive.
- R2: With captured mode 1, `obc_n` is low exactly when `line_cnt` lies in 2..3 and `pix_cnt` lies in 100..600, both inclusive.
- R3: With captured mode 2, `obc_n` is low when either the mode 0 window or the mode 1 window matches.
- R4: With captured mode 3, `obc_n` stays high for every count.
- R5: `dcr_n` is low exactly when `pix_cnt` lies in 2..12 inclusive.
- R6: `blank_n` is low exactly when `vx_cnt` lies in 1..110 inclusive.
- R7: Every output reflects the inputs sampled at the previous rising clock edge. While `rst` is high, the strobes are driven high, the qualifiers are driven low and the captured mode returns to 0.
- R8: `clamp_mode` is captured only on an edge where `frame_start` is high. The value captured on that edge first affects `obc_n` one cycle later. At any other time, changes on `clamp_mode` have no effect on `obc_n`.
- R9: `line_sync` equals `line_xfer` delayed by one cycle.
- R10: `frame_sync` rises on the edge that samples the first `line_xfer` after `frame_start`. It stays high through gaps between lines. It drops on the edge that samples `frame_end` or `frame_start`.
- R11: `pix_sync` is high one cycle after `line_xfer` is high with `pix_cnt` below 708.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_cnt | input | 10 | Pixel count within the current line |
| line_cnt | input | 9 | Line count within the current frame |
| vx_cnt | input | 7 | Count within the current vertical transfer |
| clamp_mode | input | 2 | Requested black clamp mode |
| frame_start | input | 1 | One-cycle pulse at the start of a frame; captures the mode |
| line_xfer | input | 1 | High while a line is being clocked out |
| frame_end | input | 1 | One-cycle pulse after the last line of the frame |
| obc_n | output | 1 | Optical-black clamp strobe, active low |
| dcr_n | output | 1 | DC-restore input clamp strobe, active low |
| blank_n | output | 1 | Pixel blanking strobe, active low |
| frame_sync | output | 1 | Frame qualifier for the frame grabber |
| line_sync | output | 1 | Line qualifier for the frame grabber |
| pix_sync | output | 1 | Pixel qualifier for the frame grabber |

## Verification
For each of the four clamp modes, pixel counts 0..709 are swept over line counts 0..5. This exercises both window edges, one count either side of each edge, and the rows where the dark-row window is closed. Comparing modes 1 and 2 over the same sweep distinguishes an intersection of the two windows from their union. A full sweep of the vertical-transfer count covers the blanking edges at 0, 1, 110 and 111.

A mode change is driven without `frame_start`, in the middle of a window, to show that it is not captured. Separately, `line_xfer` is run through lines, inter-line gaps and a `frame_end` pulse; this separates the qualifier that tracks a single line from the one that spans the whole frame.

// File: rtl/obc_pkg.sv
package obc_pkg;

    typedef enum logic [1:0] {
        CLMP_EOL_PIX  = 2'd0,
        CLMP_DARK_ROW = 2'd1,
        CLMP_BOTH     = 2'd2,
        CLMP_OFF      = 2'd3
    } clamp_mode_e;

    typedef struct packed {
        logic obc_n;
        logic dcr_n;
        logic blank_n;
    } strobe_t;

    typedef struct packed {
        logic frame_q;
        logic line_q;
        logic pix_q;
    } sync_t;

    localparam strobe_t STROBE_IDLE = '{obc_n: 1'b1, dcr_n: 1'b1, blank_n: 1'b1};
    localparam sync_t   SYNC_IDLE   = '{frame_q: 1'b0, line_q: 1'b0, pix_q: 1'b0};

    function automatic logic in_win(input int unsigned v, input int unsigned lo,
                                    input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/obc_win_cmp.sv
module obc_win_cmp #(
    parameter int W  = 10,
    parameter int LO = 0,
    parameter int HI = 1
) (
    input  logic [W-1:0] val,
    output logic         hit
);
    import obc_pkg::*;

    always_comb hit = in_win(int'(val), LO, HI);

endmodule

// File: rtl/obc_clamp_sel.sv
module obc_clamp_sel #(
    parameter int PIX_W       = 10,
    parameter int LINE_W      = 9,
    parameter int EOL_PIX_LO  = 696,
    parameter int EOL_PIX_HI  = 706,
    parameter int ROW_LINE_LO = 2,
    parameter int ROW_LINE_HI = 3,
    parameter int ROW_PIX_LO  = 100,
    parameter int ROW_PIX_HI  = 600
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start,
    input  logic [1:0]            mode_in,
    input  logic [PIX_W-1:0]      pix_cnt,
    input  logic [LINE_W-1:0]     line_cnt,
    output obc_pkg::clamp_mode_e  mode_q,
    output logic                  clamp_hit
);
    import obc_pkg::*;

    logic eol_hit, row_line_hit, row_pix_hit, row_hit;

    obc_win_cmp #(.W(PIX_W),  .LO(EOL_PIX_LO),  .HI(EOL_PIX_HI))
        u_eol  (.val(pix_cnt),  .hit(eol_hit));
    obc_win_cmp #(.W(LINE_W), .LO(ROW_LINE_LO), .HI(ROW_LINE_HI))
        u_rowl (.val(line_cnt), .hit(row_line_hit));
    obc_win_cmp #(.W(PIX_W),  .LO(ROW_PIX_LO),  .HI(ROW_PIX_HI))
        u_rowp (.val(pix_cnt),  .hit(row_pix_hit));

    assign row_hit = row_line_hit & row_pix_hit;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= CLMP_EOL_PIX;
        else if (frame_start)
            mode_q <= clamp_mode_e'(mode_in);
    end

    always_comb begin
        unique case (mode_q)
            CLMP_EOL_PIX:  clamp_hit = eol_hit;
            CLMP_DARK_ROW: clamp_hit = row_hit;
            CLMP_BOTH:     clamp_hit = eol_hit | row_hit;
            default:       clamp_hit = 1'b0;
        endcase
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(mode_q)); // R8

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (mode_q == $past(mode_in))); // R8

endmodule

// File: rtl/obc_sync_gen.sv
module obc_sync_gen #(
    parameter int PIX_W    = 10,
    parameter int LINE_PIX = 708
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             line_xfer,
    input  logic [PIX_W-1:0] pix_cnt,
    output obc_pkg::sync_t   sync_q
);
    import obc_pkg::*;

    logic pix_in_line;

    obc_win_cmp #(.W(PIX_W), .LO(0), .HI(LINE_PIX - 1))
        u_pix (.val(pix_cnt), .hit(pix_in_line));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= SYNC_IDLE;
        end else begin
            sync_q.line_q <= line_xfer;
            sync_q.pix_q  <= line_xfer & pix_in_line;
            if (frame_start || frame_end)
                sync_q.frame_q <= 1'b0;
            else if (line_xfer)
                sync_q.frame_q <= 1'b1;
        end
    end

    AST_LINE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        line_xfer |=> sync_q.line_q); // R9

    AST_FRAME_DROP: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !sync_q.frame_q); // R10

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sync_q.frame_q && !frame_start && !frame_end) |=> sync_q.frame_q); // R10

    AST_PIX_INSIDE_LINE: assert property (@(posedge clk) disable iff (rst)
        sync_q.pix_q |-> sync_q.line_q); // R11

endmodule

// File: rtl/obc_strobe_gen.sv
module obc_strobe_gen #(
    parameter int LINE_PIX    = 708,
    parameter int MAX_LINES   = 512,
    parameter int VX_LEN      = 128,
    parameter int EOL_PIX_LO  = 696,
    parameter int EOL_PIX_HI  = 706,
    parameter int ROW_LINE_LO = 2,
    parameter int ROW_LINE_HI = 3,
    parameter int ROW_PIX_LO  = 100,
    parameter int ROW_PIX_HI  = 600,
    parameter int DCR_LO      = 2,
    parameter int DCR_HI      = 12,
    parameter int BLK_LO      = 1,
    parameter int BLK_HI      = 110,
    localparam int PIX_W      = $clog2(LINE_PIX),
    localparam int LINE_W     = $clog2(MAX_LINES),
    localparam int VX_W       = $clog2(VX_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [VX_W-1:0]   vx_cnt,
    input  logic [1:0]        clamp_mode,
    input  logic              frame_start,
    input  logic              line_xfer,
    input  logic              frame_end,
    output logic              obc_n,
    output logic              dcr_n,
    output logic              blank_n,
    output logic              frame_sync,
    output logic              line_sync,
    output logic              pix_sync
);
    import obc_pkg::*;

    clamp_mode_e mode_q;
    logic        clamp_hit, dcr_hit, blk_hit;
    strobe_t     strobe_q;
    sync_t       sync_q;

    obc_clamp_sel #(
        .PIX_W(PIX_W), .LINE_W(LINE_W),
        .EOL_PIX_LO(EOL_PIX_LO), .EOL_PIX_HI(EOL_PIX_HI),
        .ROW_LINE_LO(ROW_LINE_LO), .ROW_LINE_HI(ROW_LINE_HI),
        .ROW_PIX_LO(ROW_PIX_LO), .ROW_PIX_HI(ROW_PIX_HI)
    ) u_clamp (
        .clk(clk), .rst(rst), .frame_start(frame_start), .mode_in(clamp_mode),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .mode_q(mode_q),
        .clamp_hit(clamp_hit)
    );

    obc_win_cmp #(.W(PIX_W), .LO(DCR_LO), .HI(DCR_HI))
        u_dcr (.val(pix_cnt), .hit(dcr_hit));
    obc_win_cmp #(.W(VX_W), .LO(BLK_LO), .HI(BLK_HI))
        u_blk (.val(vx_cnt), .hit(blk_hit));

    obc_sync_gen #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX)) u_sync (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
        .line_xfer(line_xfer), .pix_cnt(pix_cnt), .sync_q(sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= STROBE_IDLE;
        end else begin
            strobe_q.obc_n   <= ~clamp_hit;
            strobe_q.dcr_n   <= ~dcr_hit;
            strobe_q.blank_n <= ~blk_hit;
        end
    end

    assign obc_n      = strobe_q.obc_n;
    assign dcr_n      = strobe_q.dcr_n;
    assign blank_n    = strobe_q.blank_n;
    assign frame_sync = sync_q.frame_q;
    assign line_sync  = sync_q.line_q;
    assign pix_sync   = sync_q.pix_q;

    AST_CLAMP_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CLMP_OFF) |=> obc_n); // R4

    AST_EOL_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CLMP_EOL_PIX && int'(pix_cnt) >= EOL_PIX_LO
         && int'(pix_cnt) <= EOL_PIX_HI) |=> !obc_n); // R1

    AST_DCR_WIN: assert property (@(posedge clk) disable iff (rst)
        (int'(pix_cnt) >= DCR_LO && int'(pix_cnt) <= DCR_HI) |=> !dcr_n); // R5

    AST_BLANK_WIN: assert property (@(posedge clk) disable iff (rst)
        (int'(vx_cnt) >= BLK_LO && int'(vx_cnt) <= BLK_HI) |=> !blank_n); // R6

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (obc_n && dcr_n && blank_n && !frame_sync && !line_sync && !pix_sync)); // R7

endmodule

// File: tb/tb_obc_strobe_gen.sv
module tb_obc_strobe_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] pix_cnt;
    logic [8:0] line_cnt;
    logic [6:0] vx_cnt;
    logic [1:0] clamp_mode;
    logic       frame_start, line_xfer, frame_end;
    logic       obc_n, dcr_n, blank_n, frame_sync, line_sync, pix_sync;

    int checks = 0;
    int failures = 0;
    int bench_mode = 0;
    logic exp_fs = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    obc_strobe_gen dut (
        .clk(clk), .rst(rst), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .vx_cnt(vx_cnt), .clamp_mode(clamp_mode), .frame_start(frame_start),
        .line_xfer(line_xfer), .frame_end(frame_end), .obc_n(obc_n),
        .dcr_n(dcr_n), .blank_n(blank_n), .frame_sync(frame_sync),
        .line_sync(line_sync), .pix_sync(pix_sync)
    );

    function automatic bit inr(int v, int lo, int hi);
        return v >= lo && v <= hi;
    endfunction

    function automatic logic exp_obc(int m, int p, int l);
        bit eol = inr(p, 696, 706);
        bit row = inr(l, 2, 3) && inr(p, 100, 600);
        case (m)
            0: return !eol;
            1: return !row;
            2: return !(eol || row);
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive on falling edge, let one rising edge pass, check just after it
    task automatic step(int p, int l, int v, int m, bit fs, bit lx, bit fe,
                        bit full);
        logic e_obc, e_dcr, e_blk, e_ls, e_ps;
        string rq;
        @(negedge clk);
        pix_cnt = 10'(p); line_cnt = 9'(l); vx_cnt = 7'(v);
        clamp_mode = 2'(m); frame_start = fs; line_xfer = lx; frame_end = fe;
        e_obc = exp_obc(bench_mode, p, l);
        e_dcr = !inr(p, 2, 12);
        e_blk = !inr(v, 1, 110);
        e_ls  = lx;
        e_ps  = lx && (p < 708);
        if (fs || fe) exp_fs = 1'b0;
        else if (lx) exp_fs = 1'b1;
        if (fs) bench_mode = m;
        @(posedge clk);
        #1;
        case (bench_mode)
            0: rq = "R1";
            1: rq = "R2";
            2: rq = "R3";
            default: rq = "R4";
        endcase
        chk(rq, obc_n, e_obc);
        if (full) begin
            chk("R5", dcr_n, e_dcr);
            chk("R6", blank_n, e_blk);
            chk("R9", line_sync, e_ls);
            chk("R11", pix_sync, e_ps);
            chk("R10", frame_sync, exp_fs);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pix_cnt = 10'd700; line_cnt = 9'd2; vx_cnt = 7'd5; clamp_mode = 2'd3;
        frame_start = 1'b1; line_xfer = 1'b1; frame_end = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        chk("R7", obc_n, 1'b1);
        chk("R7", dcr_n, 1'b1);
        chk("R7", blank_n, 1'b1);
        chk("R7", frame_sync, 1'b0);
        chk("R7", line_sync, 1'b0);
        chk("R7", pix_sync, 1'b0);
        @(negedge clk);
        rst = 1'b0; frame_start = 1'b0; line_xfer = 1'b0;
        bench_mode = 0; exp_fs = 1'b0;
        // R7: reset leaves mode 0 active; requested 3 ignored without frame_start
        step(700, 0, 0, 3, 0, 0, 0, 1);

        // R1 R2 R3 R4 R5 R11 sweep: every mode, lines 0..5, pixels 0..709
        for (int m = 0; m < 4; m++) begin
            step(0, 0, 0, m, 1, 0, 0, 0);
            for (int l = 0; l < 6; l++)
                for (int p = 0; p < 710; p++)
                    step(p, l, 0, m, 0, 1, 0, 1);
        end

        // R6 blanking sweep over full vertical-transfer range
        for (int v = 0; v < 128; v++)
            step(0, 0, v, 3, 0, 0, 0, 1);

        // R8: mode request changes mid-frame are ignored (captured mode is 3)
        step(700, 2, 0, 0, 0, 1, 0, 1);
        step(300, 2, 0, 1, 0, 1, 0, 1);
        step(300, 2, 0, 2, 0, 1, 0, 1);
        chk("R8", obc_n, 1'b1);
        // R8: captured on frame_start, takes effect one cycle later
        step(700, 0, 0, 0, 1, 0, 0, 1);
        chk("R8", obc_n, 1'b1);
        step(700, 0, 0, 1, 0, 0, 0, 1);
        chk("R8", obc_n, 1'b0);

        // R9 R10: frame qualifier across lines, gaps and frame end
        step(0, 0, 0, 0, 1, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R10", frame_sync, 1'b0);
        step(5, 0, 0, 0, 0, 1, 0, 1);
        chk("R10", frame_sync, 1'b1);
        step(6, 0, 0, 0, 0, 1, 0, 1);
        step(0, 1, 50, 0, 0, 0, 0, 1);
        chk("R9", line_sync, 1'b0);
        chk("R10", frame_sync, 1'b1);
        step(0, 1, 0, 0, 0, 1, 0, 1);
        step(0, 1, 0, 0, 0, 0, 1, 1);
        chk("R10", frame_sync, 1'b0);
        step(0, 1, 0, 0, 0, 0, 0, 1);
        chk("R10", frame_sync, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule